// File: doc/BRIEF.md
# Multi-Channel Byte-Copy DMA Engine

The block moves bytes between a 24-bit A-side address and a 256-byte B-side register window. The A-side address is an 8-bit bank and a 16-bit offset. The B-side window is always addressed with high byte 0x21. There are `NCH` channels. Each channel holds its own setup: a control byte, a B-window index, an A offset and bank, and a 16-bit byte count. Each channel also keeps a few spare storage bytes that read back as written.

A host writes the setup through a small register port, then writes a channel mask to the start address. Every selected channel is armed. The armed channels then run one at a time, lowest index first. Each channel runs until its byte count is exhausted.

The engine drives one byte per slot on the bus. It asserts a read strobe on the source side and a write strobe on the destination side in the same cycle, and the read data is forwarded straight to the write data. `busy` stays high for the whole burst, so the host can be held off.

Top module: `gpdma_engine`

## Requirements
- R1: After reset, every channel register reads 0x00, `busy` is low and no bus strobe is asserted.
- R2: Host register address layout:
  - `{0, channel, slot}` selects a channel register; the start register has the top address bit set.
  - Slots 0 to 10 read back the last value written. Slot 0 is the control byte: bit 7 direction, bit 6 indirect flag, bit 5 spare, bit 4 step-down, bit 3 hold, bits 2:0 pattern mode.
  - Slots 11 and 15 are one shared byte.
  - Slots 12 to 14 and the start register read 0x00.
  - Slot 1 is the B index, slots 2/3 the A offset low/high, slot 4 the bank, and slots 5/6 the count low/high.
- R3: Starting and ordering:
  - A start write arms every channel whose mask bit is 1; a mask of zero starts nothing.
  - Armed channels run in ascending index order.
  - `busy` is high from the cycle after the start write until the last channel completes.
- R4: A burst occupies 1 + Σ(OVH_CYC + bytes×SLOT_CYC) cycles of `busy`. Bus strobes appear only in the last cycle of a byte slot.
- R5: Transfer direction follows control bit 7:
  - With bit 7 = 0, `a_rd` and `b_wr` fire together and `wdata` = `a_rdata`.
  - With bit 7 = 1, `b_rd` and `a_wr` fire together and `wdata` = `b_rdata`.
- R6: The B address is {0x21, (B index + offset) mod 256}. The offset is selected by the byte number k within the channel run:
  - Modes 0, 2 and 6 always use offset 0.
  - Modes 1 and 5 use k mod 2.
  - Modes 3 and 7 use (k/2) mod 2.
  - Mode 4 uses k mod 4.
- R7: After each byte slot, the A offset steps with 16-bit wrap and the bank never changes:
  - It holds when bit 3 is set.
  - Otherwise it decrements when bit 4 is set.
  - Otherwise it increments.
- R8: The count decrements once per byte and the channel stops on reaching zero. A starting count of 0 moves 65536 bytes. The final offset and a count of zero read back after the run.
- R9: Work RAM is bank 0x7E or 0x7F, or any bank with bit 6 clear and an offset below 0x2000. In B-to-A mode, when the B address is 0x2180 and the A address is in work RAM, no B read occurs and 0xFF is written to A.
- R10: In A-to-B mode, under the same port-and-work-RAM condition, no strobe is issued at all, yet the slot still takes its full time.
- R11: Host writes to channel registers or to the start register are ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | CH_W+5 | Host register address {start, channel, slot} |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Combinational register readback |
| busy | output | 1 | High while any channel is armed |
| a_addr | output | 24 | A-side address {bank, offset} |
| a_rd | output | 1 | A-side read strobe |
| a_wr | output | 1 | A-side write strobe |
| a_rdata | input | 8 | A-side read data, same cycle |
| b_addr | output | 16 | B-window address |
| b_rd | output | 1 | B-side read strobe |
| b_wr | output | 1 | B-side write strobe |
| b_rdata | input | 8 | B-side read data, same cycle |
| wdata | output | 8 | Write data for the destination side |

## Verification
The bench builds the engine with eight channels, an overhead of 3 cycles and a slot of 2 cycles instead of the default 8 and 8. Because the two values differ, a swap of the overhead and slot constants shows up in the measured `busy` length. The short slot also brings the 65536-byte zero-count run within the cycle budget. With eight channels, the start mask, the ascending service order and index wrap of the B window (0xFF to 0x00) can all be exercised at full width.

// File: rtl/gpdma_pkg.sv
package gpdma_pkg;

  // Control byte, bit order is what the host reads back
  typedef struct packed {
    logic       b_to_a;     // 7
    logic       indir;      // 6 (stored only)
    logic       spare;      // 5 (stored only)
    logic       step_dn;    // 4
    logic       step_hold;  // 3
    logic [2:0] mode;       // 2:0
  } dma_ctl_t;

  localparam logic [7:0] BWIN_PAGE = 8'h21;
  localparam logic [7:0] WRAM_PORT = 8'h80;

  localparam logic [3:0] SL_CTL   = 4'h0;
  localparam logic [3:0] SL_BIDX  = 4'h1;
  localparam logic [3:0] SL_AOFFL = 4'h2;
  localparam logic [3:0] SL_AOFFH = 4'h3;
  localparam logic [3:0] SL_BANK  = 4'h4;
  localparam logic [3:0] SL_CNTL  = 4'h5;
  localparam logic [3:0] SL_CNTH  = 4'h6;
  localparam logic [3:0] SL_XBANK = 4'h7;
  localparam logic [3:0] SL_TBLL  = 4'h8;
  localparam logic [3:0] SL_TBLH  = 4'h9;
  localparam logic [3:0] SL_LINE  = 4'hA;
  localparam logic [3:0] SL_SPA   = 4'hB;
  localparam logic [3:0] SL_SPB   = 4'hF;

  // B-window offset for byte number idx (mod 4) of a channel run
  function automatic logic [1:0] mode_offset(input logic [2:0] mode, input logic [1:0] idx);
    case (mode)
      3'd1, 3'd5: return {1'b0, idx[0]};
      3'd3, 3'd7: return {1'b0, idx[1]};
      3'd4:       return idx;
      default:    return 2'd0;
    endcase
  endfunction

  // Work RAM: full banks 7E/7F, or low 8 KiB of banks with bit 6 clear
  function automatic logic in_wram(input logic [7:0] bank, input logic [15:0] off);
    if (bank == 8'h7E || bank == 8'h7F) return 1'b1;
    if (!bank[6] && off[15:13] == 3'b000) return 1'b1;
    return 1'b0;
  endfunction

endpackage

// File: rtl/gpdma_pick.sv
module gpdma_pick #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);
  // Lowest set bit wins
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/gpdma_chan_bank.sv
module gpdma_chan_bank
  import gpdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [3:0]  host_slot,
  input  logic [7:0]  host_data,
  input  logic        arm,
  input  logic        eng_step,
  input  logic [15:0] eng_aoff,
  input  logic [15:0] eng_cnt,
  input  logic        eng_done,
  input  logic [3:0]  rd_slot,
  output logic        b_to_a,
  output logic        step_dn,
  output logic        step_hold,
  output logic [2:0]  mode,
  output logic [7:0]  bidx,
  output logic [7:0]  bank,
  output logic [15:0] aoff,
  output logic [15:0] cnt,
  output logic        active,
  output logic [7:0]  rd_data
);

  dma_ctl_t    ctl_q, ctl_d;
  logic [7:0]  bidx_q, bidx_d, bank_q, bank_d;
  logic [15:0] aoff_q, aoff_d, cnt_q, cnt_d;
  logic [7:0]  xbank_q, xbank_d, line_q, line_d, spare_q, spare_d;
  logic [15:0] tbl_q, tbl_d;
  logic        act_q, act_d;
  logic        upd;

  assign upd = host_we | arm | eng_step | eng_done;

  always_comb begin
    ctl_d   = ctl_q;
    bidx_d  = bidx_q;
    bank_d  = bank_q;
    aoff_d  = aoff_q;
    cnt_d   = cnt_q;
    xbank_d = xbank_q;
    tbl_d   = tbl_q;
    line_d  = line_q;
    spare_d = spare_q;
    act_d   = act_q;
    if (host_we) begin
      case (host_slot)
        SL_CTL:   ctl_d         = dma_ctl_t'(host_data);
        SL_BIDX:  bidx_d        = host_data;
        SL_AOFFL: aoff_d[7:0]   = host_data;
        SL_AOFFH: aoff_d[15:8]  = host_data;
        SL_BANK:  bank_d        = host_data;
        SL_CNTL:  cnt_d[7:0]    = host_data;
        SL_CNTH:  cnt_d[15:8]   = host_data;
        SL_XBANK: xbank_d       = host_data;
        SL_TBLL:  tbl_d[7:0]    = host_data;
        SL_TBLH:  tbl_d[15:8]   = host_data;
        SL_LINE:  line_d        = host_data;
        SL_SPA, SL_SPB: spare_d = host_data;
        default: ;
      endcase
    end
    if (eng_step) begin
      aoff_d = eng_aoff;
      cnt_d  = eng_cnt;
    end
    if (arm) act_d = 1'b1;
    else if (eng_done) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      bidx_q  <= '0;
      bank_q  <= '0;
      aoff_q  <= '0;
      cnt_q   <= '0;
      xbank_q <= '0;
      tbl_q   <= '0;
      line_q  <= '0;
      spare_q <= '0;
      act_q   <= 1'b0;
    end else if (upd) begin
      ctl_q   <= ctl_d;
      bidx_q  <= bidx_d;
      bank_q  <= bank_d;
      aoff_q  <= aoff_d;
      cnt_q   <= cnt_d;
      xbank_q <= xbank_d;
      tbl_q   <= tbl_d;
      line_q  <= line_d;
      spare_q <= spare_d;
      act_q   <= act_d;
    end
  end

  always_comb begin
    case (rd_slot)
      SL_CTL:   rd_data = ctl_q;
      SL_BIDX:  rd_data = bidx_q;
      SL_AOFFL: rd_data = aoff_q[7:0];
      SL_AOFFH: rd_data = aoff_q[15:8];
      SL_BANK:  rd_data = bank_q;
      SL_CNTL:  rd_data = cnt_q[7:0];
      SL_CNTH:  rd_data = cnt_q[15:8];
      SL_XBANK: rd_data = xbank_q;
      SL_TBLL:  rd_data = tbl_q[7:0];
      SL_TBLH:  rd_data = tbl_q[15:8];
      SL_LINE:  rd_data = line_q;
      SL_SPA, SL_SPB: rd_data = spare_q;
      default:  rd_data = 8'h00;
    endcase
  end

  assign b_to_a    = ctl_q.b_to_a;
  assign step_dn   = ctl_q.step_dn;
  assign step_hold = ctl_q.step_hold;
  assign mode      = ctl_q.mode;
  assign bidx      = bidx_q;
  assign bank      = bank_q;
  assign aoff      = aoff_q;
  assign cnt       = cnt_q;
  assign active    = act_q;

endmodule

// File: rtl/gpdma_seq.sv
module gpdma_seq
  import gpdma_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int CH_W     = 3,
  parameter int OVH_CYC  = 8,
  parameter int SLOT_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  active,
  input  logic            b_to_a,
  input  logic            step_dn,
  input  logic            step_hold,
  input  logic [2:0]      mode,
  input  logic [7:0]      bidx,
  input  logic [7:0]      bank,
  input  logic [15:0]     aoff,
  input  logic [15:0]     cnt,
  input  logic [7:0]      a_rdata,
  input  logic [7:0]      b_rdata,
  output logic [CH_W-1:0] cur_ch,
  output logic            step,
  output logic            done,
  output logic [15:0]     nxt_aoff,
  output logic [15:0]     nxt_cnt,
  output logic            run,
  output logic [23:0]     a_addr,
  output logic            a_rd,
  output logic            a_wr,
  output logic [15:0]     b_addr,
  output logic            b_rd,
  output logic            b_wr,
  output logic [7:0]      wdata
);

  localparam int TMAX = (OVH_CYC > SLOT_CYC) ? OVH_CYC : SLOT_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] OVH_LD  = TW'(OVH_CYC - 1);
  localparam logic [TW-1:0] SLOT_LD = TW'(SLOT_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_OVH, S_SLOT} st_t;

  st_t             st_q, st_d;
  logic [TW-1:0]   tmr_q, tmr_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [1:0]      idx_q, idx_d;
  logic            xfer, hit;
  logic [7:0]      bl;
  logic [NCH-1:0]  remaining;
  logic            rem_any;
  logic [CH_W-1:0] rem_idx;

  // Byte datapath
  always_comb begin
    xfer     = (st_q == S_SLOT) && (tmr_q == '0);
    bl       = bidx + {6'b0, mode_offset(mode, idx_q)};
    b_addr   = {BWIN_PAGE, bl};
    a_addr   = {bank, aoff};
    hit      = (bl == WRAM_PORT) && in_wram(bank, aoff);
    a_rd     = xfer && !b_to_a && !hit;
    b_wr     = xfer && !b_to_a && !hit;
    b_rd     = xfer && b_to_a && !hit;
    a_wr     = xfer && b_to_a;
    wdata    = b_to_a ? (hit ? 8'hFF : b_rdata) : a_rdata;
    nxt_aoff = step_hold ? aoff : (step_dn ? aoff - 16'd1 : aoff + 16'd1);
    nxt_cnt  = cnt - 16'd1;
    step     = xfer;
    done     = xfer && (nxt_cnt == 16'd0);
    remaining = done ? (active & ~(NCH'(1) << ch_q)) : active;
  end

  gpdma_pick #(.N(NCH), .W(CH_W)) u_pick (
    .req (remaining),
    .any (rem_any),
    .idx (rem_idx)
  );

  // Next state
  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    ch_d  = ch_q;
    idx_d = idx_q;
    case (st_q)
      S_IDLE: begin
        if (rem_any) begin
          st_d  = S_OVH;
          ch_d  = rem_idx;
          tmr_d = OVH_LD;
          idx_d = 2'd0;
        end
      end
      S_OVH: begin
        if (tmr_q == '0) begin
          st_d  = S_SLOT;
          tmr_d = SLOT_LD;
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      S_SLOT: begin
        if (tmr_q != '0) begin
          tmr_d = tmr_q - 1'b1;
        end else begin
          idx_d = idx_q + 2'd1;
          tmr_d = SLOT_LD;
          if (done) begin
            if (rem_any) begin
              st_d  = S_OVH;
              ch_d  = rem_idx;
              tmr_d = OVH_LD;
              idx_d = 2'd0;
            end else begin
              st_d = S_IDLE;
            end
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      tmr_q <= '0;
      ch_q  <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      ch_q  <= ch_d;
      idx_q <= idx_d;
    end
  end

  assign cur_ch = ch_q;
  assign run    = (st_q != S_IDLE);

endmodule

// File: rtl/gpdma_engine.sv
module gpdma_engine #(
  parameter int NCH      = 8,
  parameter int OVH_CYC  = 8,
  parameter int SLOT_CYC = 8,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int HAW     = CH_W + 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_wr,
  input  logic [HAW-1:0] host_addr,
  input  logic [7:0]     host_wdata,
  output logic [7:0]     host_rdata,
  output logic           busy,
  output logic [23:0]    a_addr,
  output logic           a_rd,
  output logic           a_wr,
  input  logic [7:0]     a_rdata,
  output logic [15:0]    b_addr,
  output logic           b_rd,
  output logic           b_wr,
  input  logic [7:0]     b_rdata,
  output logic [7:0]     wdata
);

  logic            host_ok, is_start;
  logic [CH_W-1:0] ch_field;
  logic [NCH-1:0]  b2a_v, dn_v, hold_v, act_v;
  logic [2:0]      mode_a [NCH];
  logic [7:0]      bidx_a [NCH];
  logic [7:0]      bank_a [NCH];
  logic [15:0]     aoff_a [NCH];
  logic [15:0]     cnt_a  [NCH];
  logic [7:0]      rd_a   [NCH];
  logic [CH_W-1:0] cur_ch;
  logic            eng_step, eng_done, seq_run;
  logic [15:0]     nxt_aoff, nxt_cnt;

  assign busy     = |act_v;
  assign host_ok  = host_wr & ~busy;
  assign is_start = host_addr[HAW-1];
  assign ch_field = host_addr[HAW-2:4];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    gpdma_chan_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (host_ok && !is_start && (ch_field == CH_W'(g))),
      .host_slot (host_addr[3:0]),
      .host_data (host_wdata),
      .arm       (host_ok && is_start && host_wdata[g]),
      .eng_step  (eng_step && (cur_ch == CH_W'(g))),
      .eng_aoff  (nxt_aoff),
      .eng_cnt   (nxt_cnt),
      .eng_done  (eng_done && (cur_ch == CH_W'(g))),
      .rd_slot   (host_addr[3:0]),
      .b_to_a    (b2a_v[g]),
      .step_dn   (dn_v[g]),
      .step_hold (hold_v[g]),
      .mode      (mode_a[g]),
      .bidx      (bidx_a[g]),
      .bank      (bank_a[g]),
      .aoff      (aoff_a[g]),
      .cnt       (cnt_a[g]),
      .active    (act_v[g]),
      .rd_data   (rd_a[g])
    );
  end

  always_comb begin
    if (is_start || int'(ch_field) >= NCH) host_rdata = 8'h00;
    else host_rdata = rd_a[ch_field];
  end

  gpdma_seq #(
    .NCH(NCH), .CH_W(CH_W), .OVH_CYC(OVH_CYC), .SLOT_CYC(SLOT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (act_v),
    .b_to_a    (b2a_v[cur_ch]),
    .step_dn   (dn_v[cur_ch]),
    .step_hold (hold_v[cur_ch]),
    .mode      (mode_a[cur_ch]),
    .bidx      (bidx_a[cur_ch]),
    .bank      (bank_a[cur_ch]),
    .aoff      (aoff_a[cur_ch]),
    .cnt       (cnt_a[cur_ch]),
    .a_rdata   (a_rdata),
    .b_rdata   (b_rdata),
    .cur_ch    (cur_ch),
    .step      (eng_step),
    .done      (eng_done),
    .nxt_aoff  (nxt_aoff),
    .nxt_cnt   (nxt_cnt),
    .run       (seq_run),
    .a_addr    (a_addr),
    .a_rd      (a_rd),
    .a_wr      (a_wr),
    .b_addr    (b_addr),
    .b_rd      (b_rd),
    .b_wr      (b_wr),
    .wdata     (wdata)
  );

endmodule

// File: rtl/gpdma_chk.sv
module gpdma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        run,
  input logic        a_rd,
  input logic        a_wr,
  input logic        b_rd,
  input logic        b_wr,
  input logic [15:0] b_addr,
  input logic [7:0]  wdata
);
  logic any_stb;
  assign any_stb = a_rd | a_wr | b_rd | b_wr;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_rd && a_wr) && !(b_rd && b_wr) && !(a_rd && b_rd) && !(a_wr && b_wr));

  // R5
  a2b_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd || b_wr) |-> (a_rd && b_wr));

  // R9
  port_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && !b_rd) |-> (wdata == 8'hFF));

  // R4
  stb_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> (busy && run));

  // R4
  stb_after_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> $past(busy));

  // R6
  bwin_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> (b_addr[15:8] == 8'h21));

  // R3
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !run);

endmodule

bind gpdma_engine gpdma_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .run    (seq_run),
  .a_rd   (a_rd),
  .a_wr   (a_wr),
  .b_rd   (b_rd),
  .b_wr   (b_wr),
  .b_addr (b_addr),
  .wdata  (wdata)
);

// File: tb/sim_gpdma_engine.sv
module sim_gpdma_engine;
  localparam int NCH  = 8;
  localparam int OVH  = 3;
  localparam int SLOT = 2;
  localparam int LOGN = 64;
  localparam int WD_LIMIT = 190000;
  localparam logic [7:0] START = 8'h80;

  // {ch, ctl, bidx, bank, aoff, cnt, expected final aoff}
  localparam logic [79:0] VEC [9] = '{
    80'h00_00_18_01_1000_0003_1003,
    80'h01_01_18_02_2000_0004_2004,
    80'h02_84_40_00_3000_0005_3005,
    80'h03_13_10_03_0001_0003_FFFE,
    80'h04_0D_FF_05_4444_0004_4444,
    80'h05_80_80_7E_0100_0002_0102,
    80'h06_00_80_00_1FFE_0002_2000,
    80'h07_02_80_40_0000_0002_0002,
    80'h00_05_7F_80_1000_0004_1004
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        busy;
  logic [23:0] a_addr;
  logic        a_rd, a_wr, b_rd, b_wr;
  logic [7:0]  a_rdata, b_rdata, wdata;
  logic [15:0] b_addr;

  always #10 clk = ~clk;

  function automatic logic [7:0] amem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  assign a_rdata = amem(a_addr);
  assign b_rdata = b_addr[7:0] ^ 8'hC3;

  gpdma_engine #(.NCH(NCH), .OVH_CYC(OVH), .SLOT_CYC(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
    .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr), .b_rdata(b_rdata), .wdata(wdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int ev_n = 0;
  int busy_n = 0;
  logic [51:0] lg [LOGN];

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (busy) busy_n++;
    if (a_rd | a_wr | b_rd | b_wr) begin
      if (ev_n < LOGN) lg[ev_n] = {a_addr, b_addr, a_rd, a_wr, b_rd, b_wr, wdata};
      ev_n++;
    end
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3 watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      report();
    end
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] adr(input int ch, input logic [3:0] slot);
    return {1'b0, 3'(ch), slot};
  endfunction

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic cfg(input int ch, input logic [7:0] ctl, bidx, bank,
                     input logic [15:0] aoff, cnt);
    reg_wr(adr(ch, 4'h0), ctl);
    reg_wr(adr(ch, 4'h1), bidx);
    reg_wr(adr(ch, 4'h2), aoff[7:0]);
    reg_wr(adr(ch, 4'h3), aoff[15:8]);
    reg_wr(adr(ch, 4'h4), bank);
    reg_wr(adr(ch, 4'h5), cnt[7:0]);
    reg_wr(adr(ch, 4'h6), cnt[15:8]);
  endtask

  task automatic clear_log();
    @(posedge clk);
    #1;
    ev_n = 0;
    busy_n = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  // Expected byte sequence of one channel, compared with the log from index ei
  task automatic model(input logic [7:0] ctl, bidx, bank, input logic [15:0] aoff0,
                       input int n, inout int ei, output logic [15:0] aend);
    logic [15:0] ao;
    ao = aoff0;
    for (int k = 0; k < n; k++) begin
      logic [1:0] o;
      logic [7:0] bl;
      logic [3:0] kind;
      logic [7:0] d;
      logic wr, prt;
      case (ctl[2:0])
        3'd1, 3'd5: o = 2'(k % 2);
        3'd3, 3'd7: o = 2'((k / 2) % 2);
        3'd4:       o = 2'(k % 4);
        default:    o = 2'd0;
      endcase
      bl  = bidx + 8'(o);
      wr  = (bank == 8'h7E) || (bank == 8'h7F) || (!bank[6] && ao < 16'h2000);
      prt = wr && (bl == 8'h80);
      if (!ctl[7]) begin
        kind = prt ? 4'b0000 : 4'b1001;
        d = amem({bank, ao});
      end else begin
        kind = prt ? 4'b0100 : 4'b0110;
        d = prt ? 8'hFF : (bl ^ 8'hC3);
      end
      if (kind != 4'b0000) begin
        if (ei < LOGN)
          check("R5/R6/R7/R9/R10", "bus event {a,b,strobes,data}", lg[ei],
                {bank, ao, 8'h21, bl, kind, d});
        ei++;
      end
      if (!ctl[3]) ao = ctl[4] ? ao - 16'd1 : ao + 16'd1;
    end
    aend = ao;
  endtask

  initial begin
    logic [7:0] rv, rh;
    logic [15:0] aend;
    int ei;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(adr(0, 4'h0), rv); check("R1", "ch0 control after reset", rv, 8'h00);
    reg_rd(adr(7, 4'h5), rv); check("R1", "ch7 count after reset", rv, 8'h00);
    check("R1", "busy after reset", busy, 0);
    check("R1", "strobes after reset", {a_rd, a_wr, b_rd, b_wr}, 0);

    // Vector table: one channel per run
    for (int v = 0; v < 9; v++) begin
      int ch, n;
      logic [7:0] ctl, bidx, bank;
      logic [15:0] aoff, cnt, exp_end;
      {ch, ctl, bidx, bank, aoff, cnt, exp_end} = {24'd0, VEC[v]};
      n = int'(cnt);
      cfg(ch, ctl, bidx, bank, aoff, cnt);
      clear_log();
      reg_wr(START, 8'(1 << ch));
      wait_idle();
      ei = 0;
      model(ctl, bidx, bank, aoff, n, ei, aend);
      check("R10", "event count", ev_n, ei);
      // R4 burst length
      check("R4", "busy cycles", busy_n, 1 + OVH + n * SLOT);
      reg_rd(adr(ch, 4'h2), rv); reg_rd(adr(ch, 4'h3), rh);
      check("R7", "final A offset", {rh, rv}, exp_end);
      check("R7", "model final A offset", aend, exp_end);
      reg_rd(adr(ch, 4'h4), rv); check("R7", "bank unchanged", rv, bank);
      reg_rd(adr(ch, 4'h5), rv); reg_rd(adr(ch, 4'h6), rh);
      check("R8", "final count", {rh, rv}, 16'h0000);
    end

    // R2 readback of every slot
    for (int s = 0; s < 11; s++) reg_wr(adr(3, 4'(s)), 8'(8'hA0 + s));
    for (int s = 1; s < 11; s++) begin
      reg_rd(adr(3, 4'(s)), rv);
      check("R2", "slot readback", rv, 8'hA0 + s);
    end
    reg_wr(adr(3, 4'h0), 8'hFF);
    reg_rd(adr(3, 4'h0), rv); check("R2", "control byte all ones", rv, 8'hFF);
    reg_wr(adr(3, 4'h0), 8'h6B);
    reg_rd(adr(3, 4'h0), rv); check("R2", "control byte pattern", rv, 8'h6B);
    reg_wr(adr(3, 4'hB), 8'h3C);
    reg_rd(adr(3, 4'hF), rv); check("R2", "slot 11 seen at slot 15", rv, 8'h3C);
    reg_wr(adr(3, 4'hF), 8'h5D);
    reg_rd(adr(3, 4'hB), rv); check("R2", "slot 15 seen at slot 11", rv, 8'h5D);
    reg_rd(adr(3, 4'hC), rv); check("R2", "unmapped slot", rv, 8'h00);
    reg_rd(START, rv); check("R2", "start register read", rv, 8'h00);

    // R3 zero mask starts nothing
    clear_log();
    reg_wr(START, 8'h00);
    repeat (4) @(negedge clk);
    check("R3", "busy after empty mask", busy_n, 0);

    // R3 ordering, R11 writes ignored while busy
    cfg(1, 8'h00, 8'h01, 8'h11, 16'h0100, 16'd1);
    cfg(4, 8'h00, 8'h04, 8'h14, 16'h0400, 16'd1);
    cfg(6, 8'h80, 8'h06, 8'h16, 16'h0600, 16'd2);
    clear_log();
    reg_wr(START, 8'h52);
    reg_wr(adr(6, 4'h4), 8'h99);
    reg_wr(START, 8'h08);
    wait_idle();
    ei = 0;
    model(8'h00, 8'h01, 8'h11, 16'h0100, 1, ei, aend);
    model(8'h00, 8'h04, 8'h14, 16'h0400, 1, ei, aend);
    model(8'h80, 8'h06, 8'h16, 16'h0600, 2, ei, aend);
    check("R3", "events of ordered burst", ev_n, ei);
    check("R3", "busy cycles of ordered burst", busy_n, 1 + (OVH + SLOT) * 2 + OVH + 2 * SLOT);
    reg_rd(adr(6, 4'h4), rv); check("R11", "bank write during busy", rv, 8'h16);
    reg_rd(adr(3, 4'hB), rv); check("R11", "ch3 not started during busy", rv, 8'h5D);

    // R8 count of zero moves 65536 bytes
    cfg(2, 8'h08, 8'h22, 8'h12, 16'h5555, 16'h0000);
    clear_log();
    reg_wr(START, 8'h04);
    wait_idle();
    ei = 0;
    model(8'h08, 8'h22, 8'h12, 16'h5555, 65536, ei, aend);
    check("R8", "events for zero count", ev_n, 65536);
    check("R8", "busy cycles for zero count", busy_n, 1 + OVH + 65536 * SLOT);
    reg_rd(adr(2, 4'h5), rv); reg_rd(adr(2, 4'h6), rh);
    check("R8", "count after zero-count run", {rh, rv}, 16'h0000);
    reg_rd(adr(2, 4'h2), rv); reg_rd(adr(2, 4'h3), rh);
    check("R7", "held offset", {rh, rv}, 16'h5555);

    report();
  end
endmodule